// File: doc/BRIEF.md
# Clock source switching controller

This block picks which of three oscillators drives the CPU clock: the internal high-speed oscillator, a main oscillator (crystal or externally supplied clock) and a subsystem oscillator (crystal or externally supplied clock). Software programs it through a small register bus. It writes a mode register once to say what is attached to each oscillator pin pair. It clears a stop bit to start the chosen oscillator. Last, it raises a select request. The block drives the oscillator enables, the amplifier gain settings and a two-bit clock-select code for a glitch-free multiplexer that sits outside this block.

Out of reset the CPU runs from the internal oscillator and no register needs to be written. A crystal needs time to settle before it is used. The main path therefore has a counter of main-oscillator cycles, a programmable threshold and a thermometer status register. The subsystem path waits a fixed cycle count. A select request made too early stays pending. The select output moves only when the target source is ready, or at once for an external clock. The source that is driving the clock now can be read back.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset, clk_sel is 00 (internal oscillator), both stop bits read 1 (STOP register, address 1, bit0 main, bit1 sub), both oscillator enables are 0, STAT (address 3) reads 0 and the active-source field SEL[5:4] (address 4) reads 00.
- R2: The mode register (address 0) takes only the first write after reset. Later writes leave it and its outputs unchanged until the next reset. Mode bits: [0] main external clock, [1] main oscillator in use, [2] main high gain, [4] sub external clock, [5] sub oscillator in use, [7:6] sub drive level.
- R3: main_hi_gain equals mode bit 2 when main external clock is 0, and is forced to 0 when main external clock is 1. main_ext_clk follows mode bit 0.
- R4: sub_drive equals mode bits [7:6] when sub external clock is 0, and is forced to 00 when it is 1.
- R5: An oscillator enable is 1 exactly when its mode "in use" bit is 1 and its stop bit is 0.
- R6: The main stabilization counter is cleared while the main enable is 0 and counts main_osc_tick cycles while it is 1. STAT bit i is set once the count reaches 4<<i (4, 8, 16, 32 cycles with default parameters), forming a thermometer code. It saturates at the longest time, and it returns to 0 when the main stop bit is set.
- R7: With a main crystal, a main request (SEL bit0) is held pending. clk_sel becomes 01 one cycle after STAT bit WSEL (address 2) is set.
- R8: With the main external clock selected and enabled, clk_sel becomes 01 one cycle after the main request, with no oscillator cycles needed.
- R9: A sub request (SEL bit1) moves clk_sel to 10 only after SUB_WAIT (default 8) sub_osc_tick cycles with the sub enable at 1, or at once when the sub external clock is selected.
- R10: SEL[5:4] reads back the current clk_sel. Clearing both requests returns clk_sel to 00 one cycle later.
- R11: When both requests are set and both sources are ready, the main source wins (clk_sel 01).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| main_osc_tick | input | 1 | One pulse per main oscillator cycle |
| sub_osc_tick | input | 1 | One pulse per subsystem oscillator cycle |
| main_osc_en | output | 1 | Main oscillator enable |
| main_ext_clk | output | 1 | Main pin pair takes an external clock |
| main_hi_gain | output | 1 | Main amplifier high-gain setting |
| sub_osc_en | output | 1 | Subsystem oscillator enable |
| sub_ext_clk | output | 1 | Sub pin pair takes an external clock |
| sub_drive | output | 2 | Subsystem amplifier drive level |
| clk_sel | output | 2 | CPU clock select: 00 internal, 01 main, 10 sub |

## Verification
The hardest state to reach is a pending main request that sits on a crystal source while the counter passes its lower thresholds. The switch must happen only at the chosen one. The table of vectors reaches this by resetting each time and writing the mode, threshold, stop and request registers in the software order. It then feeds a counted burst of oscillator pulses that stops just short of the threshold or lands on it, and compares the thermometer status and the select code. Write-once and forced-zero gain behaviour are reached by a second mode write after reset and by external-clock mode values.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10
  } src_e;

  typedef struct packed {
    logic [1:0] sub_drive;
    logic       sub_osc;
    logic       sub_ext;
    logic       rsv;
    logic       main_hi;
    logic       main_osc;
    logic       main_ext;
  } mode_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_STOP = 3'd1;
  localparam logic [2:0] A_WSEL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_SEL  = 3'd4;
endpackage

// File: rtl/clksrc_regs.sv
module clksrc_regs
  import clksrc_pkg::*;
#(
  parameter int NSEL   = 4,
  parameter int WSEL_W = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output mode_t             mode,
  output logic              main_stop,
  output logic              sub_stop,
  output logic [WSEL_W-1:0] wsel,
  output logic              req_main,
  output logic              req_sub
);
  logic              mode_done_q, mode_done_d;
  mode_t             mode_q, mode_d;
  logic              mstop_q, mstop_d, sstop_q, sstop_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic              rm_q, rm_d, rs_q, rs_d;
  logic              mode_we;

  assign mode_we = wr_en && (addr == A_MODE) && !mode_done_q;

  always_comb begin
    mode_d      = mode_q;
    mode_done_d = mode_done_q;
    mstop_d     = mstop_q;
    sstop_d     = sstop_q;
    wsel_d      = wsel_q;
    rm_d        = rm_q;
    rs_d        = rs_q;
    if (mode_we) begin
      mode_d      = mode_t'(wdata);
      mode_done_d = 1'b1;
    end
    if (wr_en && addr == A_STOP) begin
      mstop_d = wdata[0];
      sstop_d = wdata[1];
    end
    if (wr_en && addr == A_WSEL) begin
      if (int'(wdata[WSEL_W-1:0]) >= NSEL) wsel_d = WSEL_W'(NSEL - 1);
      else                                 wsel_d = wdata[WSEL_W-1:0];
    end
    if (wr_en && addr == A_SEL) begin
      rm_d = wdata[0];
      rs_d = wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      mode_done_q <= 1'b0;
      mstop_q     <= 1'b1;
      sstop_q     <= 1'b1;
      wsel_q      <= '0;
      rm_q        <= 1'b0;
      rs_q        <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      mode_done_q <= mode_done_d;
      mstop_q     <= mstop_d;
      sstop_q     <= sstop_d;
      wsel_q      <= wsel_d;
      rm_q        <= rm_d;
      rs_q        <= rs_d;
    end
  end

  assign mode      = mode_q;
  assign main_stop = mstop_q;
  assign sub_stop  = sstop_q;
  assign wsel      = wsel_q;
  assign req_main  = rm_q;
  assign req_sub   = rs_q;

  assert_mode_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done_q && wr_en && addr == A_MODE) |=> $stable(mode_q));
endmodule

// File: rtl/clksrc_stab.sv
module clksrc_stab #(
  parameter int NSEL     = 4,
  parameter int BASE_LOG = 2,
  localparam int CW      = BASE_LOG + NSEL,
  localparam int MAXC    = 1 << (BASE_LOG + NSEL - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_en,
  input  logic            tick,
  output logic [NSEL-1:0] stat
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!osc_en)                             cnt_d = '0;
    else if (tick && (cnt_q < CW'(MAXC)))    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_thr
    assign stat[i] = (cnt_q >= CW'(1 << (BASE_LOG + i)));
  end

  assert_thermo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat + NSEL'(1)) & stat) == '0);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (stat == '0));
endmodule

// File: rtl/clksrc_subwait.sv
module clksrc_subwait #(
  parameter int SUB_WAIT = 8,
  localparam int SW      = $clog2(SUB_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic tick,
  output logic done
);
  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!osc_en)                                 cnt_d = '0;
    else if (tick && (cnt_q < SW'(SUB_WAIT)))    cnt_d = cnt_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == SW'(SUB_WAIT));

  assert_sub_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !done);
endmodule

// File: rtl/clksrc_switch.sv
module clksrc_switch
  import clksrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_main,
  input  logic       req_sub,
  input  logic       main_ready,
  input  logic       sub_ready,
  output logic [1:0] sel
);
  src_e sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (req_main) begin
      if (main_ready) sel_d = SRC_MAIN;
    end else if (req_sub) begin
      if (sub_ready) sel_d = SRC_SUB;
    end else begin
      sel_d = SRC_INT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SRC_INT;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;

  assert_main_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_MAIN && $past(sel_q) != SRC_MAIN) |-> $past(main_ready && req_main));
  assert_sub_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_SUB && $past(sel_q) != SRC_SUB) |-> $past(sub_ready && req_sub));
  assert_idle_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_main && !req_sub) |=> (sel_q == SRC_INT));
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int NSEL     = 4,
  parameter int BASE_LOG = 2,
  parameter int SUB_WAIT = 8,
  localparam int WSEL_W  = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       main_osc_tick,
  input  logic       sub_osc_tick,
  output logic       main_osc_en,
  output logic       main_ext_clk,
  output logic       main_hi_gain,
  output logic       sub_osc_en,
  output logic       sub_ext_clk,
  output logic [1:0] sub_drive,
  output logic [1:0] clk_sel
);
  mode_t             mode;
  logic              main_stop, sub_stop, req_main, req_sub;
  logic [WSEL_W-1:0] wsel;
  logic [NSEL-1:0]   stat;
  logic              sub_done, main_ready, sub_ready;

  clksrc_regs #(.NSEL(NSEL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode(mode), .main_stop(main_stop), .sub_stop(sub_stop), .wsel(wsel),
    .req_main(req_main), .req_sub(req_sub)
  );

  assign main_osc_en  = mode.main_osc && !main_stop;
  assign sub_osc_en   = mode.sub_osc && !sub_stop;
  assign main_ext_clk = mode.main_ext;
  assign sub_ext_clk  = mode.sub_ext;
  assign main_hi_gain = mode.main_hi && !mode.main_ext;
  assign sub_drive    = mode.sub_ext ? 2'b00 : mode.sub_drive;

  clksrc_stab #(.NSEL(NSEL), .BASE_LOG(BASE_LOG)) u_stab (
    .clk(clk), .rst_n(rst_n), .osc_en(main_osc_en), .tick(main_osc_tick),
    .stat(stat)
  );

  clksrc_subwait #(.SUB_WAIT(SUB_WAIT)) u_subw (
    .clk(clk), .rst_n(rst_n), .osc_en(sub_osc_en), .tick(sub_osc_tick),
    .done(sub_done)
  );

  assign main_ready = main_osc_en && (mode.main_ext || stat[wsel]);
  assign sub_ready  = sub_osc_en && (mode.sub_ext || sub_done);

  clksrc_switch u_sw (
    .clk(clk), .rst_n(rst_n), .req_main(req_main), .req_sub(req_sub),
    .main_ready(main_ready), .sub_ready(sub_ready), .sel(clk_sel)
  );

  always_comb begin
    case (addr)
      A_MODE:  rdata = mode;
      A_STOP:  rdata = {6'b0, sub_stop, main_stop};
      A_WSEL:  rdata = 8'(wsel);
      A_STAT:  rdata = 8'(stat);
      A_SEL:   rdata = {2'b0, clk_sel, 2'b0, req_sub, req_main};
      default: rdata = 8'h00;
    endcase
  end

  assert_gain_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    main_ext_clk |-> !main_hi_gain);
  assert_drive_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ext_clk |-> (sub_drive == 2'b00));
endmodule

// File: tb/clksrc_ctrl_tb_top.sv
module clksrc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, wr_en, mt, st;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       main_osc_en, main_ext_clk, main_hi_gain, sub_osc_en, sub_ext_clk;
  logic [1:0] sub_drive, clk_sel;
  int n_chk, n_bad;

  clksrc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .main_osc_tick(mt), .sub_osc_tick(st),
    .main_osc_en(main_osc_en), .main_ext_clk(main_ext_clk),
    .main_hi_gain(main_hi_gain), .sub_osc_en(sub_osc_en),
    .sub_ext_clk(sub_ext_clk), .sub_drive(sub_drive), .clk_sel(clk_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // vector: {wsel[3:0], ticks[7:0], expected clk_sel[3:0]}
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {4'd0, 8'd3,  4'd0}, {4'd0, 8'd4,  4'd1}, {4'd1, 8'd7,  4'd0},
    {4'd1, 8'd8,  4'd1}, {4'd2, 8'd16, 4'd1}, {4'd3, 8'd31, 4'd0},
    {4'd3, 8'd40, 4'd1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; addr = 3'd0; wdata = 8'h00; mt = 1'b0; st = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic mticks(input int n);
    @(negedge clk);
    mt = 1'b1;
    repeat (n) @(negedge clk);
    mt = 1'b0;
  endtask

  task automatic sticks(input int n);
    @(negedge clk);
    st = 1'b1;
    repeat (n) @(negedge clk);
    st = 1'b0;
  endtask

  function automatic logic [7:0] thermo(input int n);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 4; i++) if (n >= (4 << i)) r[i] = 1'b1;
    return r;
  endfunction

  initial begin
    logic [7:0] v;
    n_chk = 0; n_bad = 0;

    // R7 / R6: main crystal vectors
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(3'd0, 8'h02);
      wr(3'd2, {4'd0, VEC[k][15:12]});
      wr(3'd1, 8'h02);
      wr(3'd4, 8'h01);
      mticks(int'(VEC[k][11:4]));
      repeat (2) @(negedge clk);
      check("R7 clk_sel", {6'b0, clk_sel}, {4'b0, VEC[k][3:0]});
      rd(3'd3, v);
      check("R6 stat", v, thermo(int'(VEC[k][11:4])));
    end

    // R1 reset state
    do_reset();
    check("R1 clk_sel", {6'b0, clk_sel}, 8'h00);
    check("R1 enables", {6'b0, main_osc_en, sub_osc_en}, 8'h00);
    rd(3'd1, v); check("R1 stop", v, 8'h03);
    rd(3'd3, v); check("R1 stat", v, 8'h00);
    rd(3'd4, v); check("R1 sel", v, 8'h00);

    // R2 write-once, R5 enable
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h05);
    rd(3'd0, v); check("R2 mode", v, 8'h02);
    check("R2 ext out", {7'b0, main_ext_clk}, 8'h00);
    check("R5 en stopped", {7'b0, main_osc_en}, 8'h00);
    wr(3'd1, 8'h02);
    check("R5 en running", {7'b0, main_osc_en}, 8'h01);
    // R6 counter clears when stopped
    mticks(10);
    rd(3'd3, v); check("R6 stat counted", v, 8'h03);
    wr(3'd1, 8'h03);
    rd(3'd3, v); check("R6 stat cleared", v, 8'h00);

    // R3 gain
    do_reset(); wr(3'd0, 8'h07);
    check("R3 gain ext", {6'b0, main_ext_clk, main_hi_gain}, 8'h02);
    do_reset(); wr(3'd0, 8'h06);
    check("R3 gain xtal", {6'b0, main_ext_clk, main_hi_gain}, 8'h01);

    // R4 sub drive
    do_reset(); wr(3'd0, 8'hE0);
    check("R4 drive xtal", {6'b0, sub_drive}, 8'h03);
    do_reset(); wr(3'd0, 8'hF0);
    check("R4 drive ext", {6'b0, sub_drive}, 8'h00);

    // R8 external main, R10 readback and return
    do_reset();
    wr(3'd0, 8'h03); wr(3'd1, 8'h02); wr(3'd4, 8'h01);
    @(negedge clk);
    check("R8 ext switch", {6'b0, clk_sel}, 8'h01);
    rd(3'd4, v); check("R10 sel readback", v, 8'h11);
    wr(3'd4, 8'h00);
    @(negedge clk);
    check("R10 back to int", {6'b0, clk_sel}, 8'h00);

    // R9 sub crystal wait
    do_reset();
    wr(3'd0, 8'h20); wr(3'd1, 8'h01); wr(3'd4, 8'h02);
    sticks(7);
    repeat (2) @(negedge clk);
    check("R9 sub pending", {6'b0, clk_sel}, 8'h00);
    sticks(1);
    repeat (2) @(negedge clk);
    check("R9 sub switched", {6'b0, clk_sel}, 8'h02);

    // R11 priority
    do_reset();
    wr(3'd0, 8'h33); wr(3'd1, 8'h00); wr(3'd4, 8'h03);
    repeat (2) @(negedge clk);
    check("R11 main wins", {6'b0, clk_sel}, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule